// File: doc/BRIEF.md
# Space Vector PWM Gate Generator

This block produces the six gate signals of a two-level, three-phase inverter bridge by space vector modulation. A reference vector turns at one-degree resolution through six 60-degree sectors. The speed is set by an 8-bit frequency command. The length of the vector comes from an 8-bit modulation index. Every switching period, the block works out how long to apply each of the two active vectors that bound the current sector, and how long to apply a zero vector. It then plays those intervals out as a symmetric sequence. Each leg drives a complementary upper/lower pair, with a programmable dead time between them.

All inputs are plain control pins and carry no handshake. The block samples the modulation index, the dead time and the reference angle once, at the first cycle of each switching period, and holds them for the whole period. The frequency command is folded into the phase accumulator at that same instant. The default period of 4167 cycles gives 24 kHz from a 100 MHz clock, so every sector lasts a whole number of periods.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst` is high or `en` is low, all six gates are low from the next clock edge on. The state returns to angle 0, sector 0, with the all-low zero vector next. The first period starts on the edge that samples `rst` low and `en` high, and the lower gates come on at that edge.
- R2: A switching period lasts exactly PERIOD_CYC cycles. Its intervals come in this order: zero vector for floor(T0/2) cycles, first active vector for Ta cycles, second active vector for Tb cycles, and zero vector for the remaining cycles. T0 = PERIOD_CYC - Ta - Tb.
- R3: Vectors are 3-bit patterns with bit0 = phase A, bit1 = phase B and bit2 = phase C, where 1 means the upper switch is on. The six active vectors in rotation order are 001, 011, 010, 110, 100, 101. Sector k (0 to 5) applies vector k of that list first, then vector k+1, where the vector after 101 is 001.
- R4: The zero vector is 000 in the first period after a restart. It then alternates between 111 and 000 from one period to the next.
- R5: With S(x) = round(4096*sin(x degrees)), Ta = floor(PERIOD_CYC*m*S(60-phi)/2^20) and Tb = floor(PERIOD_CYC*m*S(phi)/2^20). Here phi is the in-sector angle in degrees and m is the clamped index.
- R6: The modulation index is an unsigned fraction of 256. It is clamped to the range 26 to 205 and latched at period start, as is `dead_cyc`.
- R7: At each period start, `freq_cmd` is added to an 8-bit fraction. A carry out advances the angle by one degree. Phi wraps from 59 to 0 and moves the sector on, and sector 5 wraps to sector 0. A period uses the angle held before that advance.
- R8: When the desired upper state of a leg changes, both of its gates are off for `dead_cyc` cycles, and then the new side turns on. A dead time of 0 switches the pair at once. Gates follow the desired state with one register stage.
- R9: The upper and lower gate of a leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the block in its restart state |
| freq_cmd | input | 8 | Degrees advanced per period, as a fraction of 256 |
| mod_idx | input | 8 | Modulation index, as a fraction of 256 |
| dead_cyc | input | 8 | Dead time in clock cycles |
| gate_hi | output | 3 | Upper switch gates; bit0 = A, bit1 = B, bit2 = C |
| gate_lo | output | 3 | Lower switch gates; bit0 = A, bit1 = B, bit2 = C |

## Verification
The hardest case to reach from the ports is a full turn of the angle. That turn crosses all six sector boundaries and the wrap from 359 back to 0 degrees, and at the default period and a slow command it would take millions of cycles. The bench shortens the period parameter and holds the frequency command near its top value, so one degree passes per period and a full revolution fits in a few hundred periods. Clamp limits, zero and long dead times, and a stalled angle are each reached by restarting through `en` or `rst` with new pin values.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  localparam int SECTORS     = 6;
  localparam int SECTOR_DEG  = 60;
  localparam int SIN_FRAC    = 12;
  localparam int IDX_FRAC    = 8;
  localparam int SIN_W       = SIN_FRAC + 1;

  // Fixed-point Taylor sum in Q28, evaluated at elaboration only.
  function automatic logic [SIN_W-1:0] sin_deg_q(input int deg);
    longint x, x2, term, acc;
    x    = (longint'(deg) * 64'sd843314857) / 64'sd180;
    x2   = (x * x) >>> 28;
    term = x;
    acc  = x;
    for (int k = 1; k <= 5; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return SIN_W'((acc + (64'sd1 <<< 15)) >>> 16);
  endfunction

  // Active vector k of the rotation (bit0 = phase A upper on).
  function automatic logic [2:0] active_vec(input logic [2:0] k);
    case (k)
      3'd0:    return 3'b001;
      3'd1:    return 3'b011;
      3'd2:    return 3'b010;
      3'd3:    return 3'b110;
      3'd4:    return 3'b100;
      3'd5:    return 3'b101;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/svpwm_phase_acc.sv
module svpwm_phase_acc (
  input  logic       clk,
  input  logic       hold,
  input  logic       adv,
  input  logic [7:0] freq_cmd,
  output logic [2:0] ang_sec,
  output logic [5:0] ang_phi
);
  import svpwm_pkg::*;

  logic [7:0] frac;
  logic [8:0] sum;

  assign sum = {1'b0, frac} + {1'b0, freq_cmd};

  always_ff @(posedge clk) begin
    if (hold) begin
      frac    <= '0;
      ang_sec <= '0;
      ang_phi <= '0;
    end else if (adv) begin
      frac <= sum[7:0];
      if (sum[8]) begin
        if (ang_phi == 6'(SECTOR_DEG - 1)) begin
          ang_phi <= '0;
          ang_sec <= (ang_sec == 3'(SECTORS - 1)) ? 3'd0 : ang_sec + 3'd1;
        end else begin
          ang_phi <= ang_phi + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/svpwm_dwell.sv
module svpwm_dwell #(
  parameter int PERIOD_CYC = 4167,
  parameter int DW         = $clog2(PERIOD_CYC + 1)
) (
  input  logic [5:0]    phi,
  input  logic [7:0]    m,
  output logic [DW-1:0] dwell_a,
  output logic [DW-1:0] dwell_b
);
  import svpwm_pkg::*;

  localparam int PW = DW + IDX_FRAC + SIN_W + 2;
  localparam int SH = IDX_FRAC + SIN_FRAC;

  logic [SIN_W-1:0] sin_rom [0:SECTOR_DEG];

  for (genvar i = 0; i <= SECTOR_DEG; i++) begin : g_rom
    localparam logic [SIN_W-1:0] SV = sin_deg_q(i);
    assign sin_rom[i] = SV;
  end

  logic [5:0]    rest;
  logic [PW-1:0] prod_a, prod_b;

  always_comb begin
    rest    = 6'(SECTOR_DEG) - phi;
    prod_a  = PW'(PERIOD_CYC) * PW'(m) * PW'(sin_rom[rest]);
    prod_b  = PW'(PERIOD_CYC) * PW'(m) * PW'(sin_rom[phi]);
    dwell_a = DW'(prod_a >> SH);
    dwell_b = DW'(prod_b >> SH);
  end
endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq #(
  parameter int PERIOD_CYC = 4167,
  parameter int M_MIN      = 26,
  parameter int M_MAX      = 205,
  parameter int DW         = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          hold,
  input  logic [2:0]    ang_sec,
  input  logic [5:0]    ang_phi,
  input  logic [7:0]    mod_idx,
  input  logic [7:0]    dead_cyc,
  input  logic [DW-1:0] dwell_a,
  input  logic [DW-1:0] dwell_b,
  output logic          adv,
  output logic [5:0]    per_phi,
  output logic [7:0]    per_m,
  output logic [7:0]    per_dt,
  output logic [2:0]    want
);
  import svpwm_pkg::*;

  logic [DW-1:0] cnt;
  logic          started;
  logic          zero_hi;
  logic [2:0]    per_sec;
  logic [7:0]    m_cl;
  logic          last;

  assign last = (cnt == DW'(PERIOD_CYC - 1));
  assign adv  = last & ~hold;

  always_comb begin
    if (mod_idx < 8'(M_MIN))      m_cl = 8'(M_MIN);
    else if (mod_idx > 8'(M_MAX)) m_cl = 8'(M_MAX);
    else                          m_cl = mod_idx;
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt     <= DW'(PERIOD_CYC - 1);
      started <= 1'b0;
      zero_hi <= 1'b0;
      per_sec <= '0;
      per_phi <= '0;
      per_m   <= 8'(M_MIN);
      per_dt  <= '0;
    end else if (last) begin
      cnt     <= '0;
      started <= 1'b1;
      zero_hi <= started & ~zero_hi;
      per_sec <= ang_sec;
      per_phi <= ang_phi;
      per_m   <= m_cl;
      per_dt  <= dead_cyc;
    end else begin
      cnt <= cnt + DW'(1);
    end
  end

  logic [DW-1:0] t0, edge1, edge2, edge3;
  logic [2:0]    vec_a, vec_b, zvec, nxt_sec;

  always_comb begin
    t0      = DW'(PERIOD_CYC) - dwell_a - dwell_b;
    edge1   = t0 >> 1;
    edge2   = edge1 + dwell_a;
    edge3   = edge2 + dwell_b;
    nxt_sec = (per_sec == 3'(SECTORS - 1)) ? 3'd0 : per_sec + 3'd1;
    vec_a   = active_vec(per_sec);
    vec_b   = active_vec(nxt_sec);
    zvec    = {3{zero_hi}};
    if (!started)         want = 3'b000;
    else if (cnt < edge1) want = zvec;
    else if (cnt < edge2) want = vec_a;
    else if (cnt < edge3) want = vec_b;
    else                  want = zvec;
  end
endmodule

// File: rtl/svpwm_dead_leg.sv
module svpwm_dead_leg (
  input  logic       clk,
  input  logic       hold,
  input  logic [7:0] dead,
  input  logic       want_hi,
  output logic       gate_hi,
  output logic       gate_lo
);
  logic       side;
  logic [7:0] wait_c;

  always_ff @(posedge clk) begin
    if (hold) begin
      side    <= 1'b0;
      wait_c  <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (want_hi != side) begin
      side <= want_hi;
      if (dead == 8'd0) begin
        gate_hi <= want_hi;
        gate_lo <= ~want_hi;
        wait_c  <= '0;
      end else begin
        gate_hi <= 1'b0;
        gate_lo <= 1'b0;
        wait_c  <= dead - 8'd1;
      end
    end else if (wait_c != 8'd0) begin
      wait_c <= wait_c - 8'd1;
    end else begin
      gate_hi <= side;
      gate_lo <= ~side;
    end
  end
endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen #(
  parameter int PERIOD_CYC = 4167,
  parameter int M_MIN      = 26,
  parameter int M_MAX      = 205
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [7:0] freq_cmd,
  input  logic [7:0] mod_idx,
  input  logic [7:0] dead_cyc,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);
  localparam int DW = $clog2(PERIOD_CYC + 1);

  logic          hold;
  logic          adv;
  logic [2:0]    ang_sec;
  logic [5:0]    ang_phi;
  logic [5:0]    per_phi;
  logic [7:0]    per_m;
  logic [7:0]    per_dt;
  logic [DW-1:0] dwell_a, dwell_b;
  logic [2:0]    want;

  assign hold = rst | ~en;

  svpwm_phase_acc u_acc (
    .clk(clk), .hold(hold), .adv(adv), .freq_cmd(freq_cmd),
    .ang_sec(ang_sec), .ang_phi(ang_phi)
  );

  svpwm_dwell #(.PERIOD_CYC(PERIOD_CYC), .DW(DW)) u_dwell (
    .phi(per_phi), .m(per_m), .dwell_a(dwell_a), .dwell_b(dwell_b)
  );

  svpwm_seq #(.PERIOD_CYC(PERIOD_CYC), .M_MIN(M_MIN), .M_MAX(M_MAX), .DW(DW)) u_seq (
    .clk(clk), .hold(hold), .ang_sec(ang_sec), .ang_phi(ang_phi),
    .mod_idx(mod_idx), .dead_cyc(dead_cyc), .dwell_a(dwell_a), .dwell_b(dwell_b),
    .adv(adv), .per_phi(per_phi), .per_m(per_m), .per_dt(per_dt), .want(want)
  );

  for (genvar g = 0; g < 3; g++) begin : g_leg
    svpwm_dead_leg u_leg (
      .clk(clk), .hold(hold), .dead(per_dt), .want_hi(want[g]),
      .gate_hi(gate_hi[g]), .gate_lo(gate_lo[g])
    );
  end
endmodule

// File: rtl/svpwm_gate_chk.sv
module svpwm_gate_chk #(
  parameter int PERIOD_CYC = 4167,
  parameter int M_MIN      = 26,
  parameter int M_MAX      = 205,
  parameter int DW         = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [2:0]    gate_hi,
  input logic [2:0]    gate_lo,
  input logic [2:0]    ang_sec,
  input logic [5:0]    ang_phi,
  input logic [7:0]    per_m,
  input logic [7:0]    per_dt,
  input logic [DW-1:0] dwell_a,
  input logic [DW-1:0] dwell_b
);
  // R9
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    ((gate_hi & gate_lo) == 3'b000));

  // R1
  hold_low_chk: assert property (@(posedge clk)
    (rst || !en) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  // R7
  angle_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ang_sec < 3'd6 && ang_phi < 6'd60));

  // R5
  zero_room_chk: assert property (@(posedge clk) disable iff (rst)
    ((32'(dwell_a) + 32'(dwell_b)) < 32'(PERIOD_CYC)));

  // R6
  idx_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (per_m >= 8'(M_MIN) && per_m <= 8'(M_MAX)));

  for (genvar i = 0; i < 3; i++) begin : g_gap
    // R8
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst || !en)
      (per_dt != 8'd0 && $fell(gate_lo[i])) |-> !gate_hi[i]);
    // R8
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst || !en)
      (per_dt != 8'd0 && $fell(gate_hi[i])) |-> !gate_lo[i]);
  end
endmodule

bind svpwm_gate_gen svpwm_gate_chk #(
  .PERIOD_CYC(PERIOD_CYC), .M_MIN(M_MIN), .M_MAX(M_MAX), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .ang_sec(ang_sec), .ang_phi(ang_phi), .per_m(per_m), .per_dt(per_dt),
  .dwell_a(dwell_a), .dwell_b(dwell_b)
);

// File: tb/svpwm_gate_gen_test.sv
`timescale 1ns/1ps
module svpwm_gate_gen_test;
  localparam int P    = 120;
  localparam int MMIN = 26;
  localparam int MMAX = 205;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] freq = 8'd0, midx = 8'd0, dead = 8'd0;
  logic [2:0] gh, gl;

  svpwm_gate_gen #(.PERIOD_CYC(P)) uut (
    .clk(clk), .rst(rst), .en(en), .freq_cmd(freq), .mod_idx(midx),
    .dead_cyc(dead), .gate_hi(gh), .gate_lo(gl)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int sinq [0:60];
  bit seen [0:7];
  bit track = 0;
  bit done  = 0;

  // reference state
  int r_cnt, r_ang, r_frac, r_z, r_started, r_sec, r_phi, r_m, r_dt;
  int l_side [3], l_wait [3], l_hi [3], l_lo [3];

  function automatic int vec_pat(int k);
    case (k % 6)
      0: return 1;
      1: return 3;
      2: return 2;
      3: return 6;
      4: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int ref_want();
    longint ta, tb, t0, z1;
    if (r_started == 0) return 0;
    ta = (longint'(P) * r_m * sinq[60 - r_phi]) >>> 20;
    tb = (longint'(P) * r_m * sinq[r_phi]) >>> 20;
    t0 = P - ta - tb;
    z1 = t0 / 2;
    if (r_cnt < z1)                return r_z ? 7 : 0;
    else if (r_cnt < z1 + ta)      return vec_pat(r_sec);
    else if (r_cnt < z1 + ta + tb) return vec_pat(r_sec + 1);
    else                           return r_z ? 7 : 0;
  endfunction

  always @(posedge clk) begin
    int dv, b;
    if (rst || !en) begin
      r_cnt = P - 1; r_ang = 0; r_frac = 0; r_z = 0; r_started = 0;
      r_sec = 0; r_phi = 0; r_m = MMIN; r_dt = 0;
      for (int i = 0; i < 3; i++) begin
        l_side[i] = 0; l_wait[i] = 0; l_hi[i] = 0; l_lo[i] = 0;
      end
    end else begin
      dv = ref_want();
      for (int i = 0; i < 3; i++) begin
        b = (dv >> i) & 1;
        if (b != l_side[i]) begin
          l_side[i] = b;
          if (r_dt == 0) begin
            l_hi[i] = b; l_lo[i] = 1 - b; l_wait[i] = 0;
          end else begin
            l_hi[i] = 0; l_lo[i] = 0; l_wait[i] = r_dt - 1;
          end
        end else if (l_wait[i] > 0) begin
          l_wait[i] = l_wait[i] - 1;
        end else begin
          l_hi[i] = l_side[i]; l_lo[i] = 1 - l_side[i];
        end
      end
      if (r_cnt == P - 1) begin
        r_sec = r_ang / 60;
        r_phi = r_ang % 60;
        r_m   = (midx < MMIN) ? MMIN : ((midx > MMAX) ? MMAX : int'(midx));
        r_dt  = dead;
        r_z   = r_started ? 1 - r_z : 0;
        r_started = 1;
        r_frac = r_frac + freq;
        if (r_frac >= 256) begin
          r_frac = r_frac - 256;
          r_ang  = (r_ang + 1) % 360;
        end
        r_cnt = 0;
      end else begin
        r_cnt = r_cnt + 1;
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    int eh, el;
    if (!done) begin
      eh = l_hi[0] | (l_hi[1] << 1) | (l_hi[2] << 2);
      el = l_lo[0] | (l_lo[1] << 1) | (l_lo[2] << 2);
      vectors++;
      if (gh !== 3'(eh) || gl !== 3'(el)) begin
        errors++;
        $display("FAIL R2 R3 R4 R5 R6 R7 R8 gates at %0t: hi=%b lo=%b expected hi=%b lo=%b",
                 $time, gh, gl, 3'(eh), 3'(el));
      end
      vectors++;
      if ((gh & gl) != 3'b000) begin
        errors++;
        $display("FAIL R9 overlap at %0t: hi&lo=%b expected 000", $time, gh & gl);
      end
      if (track) seen[gh] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [5:0] snap [0:2*P-1];

  initial begin
    int cnt_seen, diffs;
    for (int i = 0; i <= 60; i++)
      sinq[i] = $rtoi($sin(real'(i) * 3.14159265358979 / 180.0) * 4096.0 + 0.5);

    // R1: reset holds all gates low
    cycles(4);
    check(gh == 3'b000 && gl == 3'b000, "R1 reset gates low", {gh, gl}, 0);

    // full revolution: near one degree per period
    freq = 8'd255; midx = 8'd128; dead = 8'd3; en = 1'b1;
    @(negedge clk);
    check(gh == 3'b000 && gl == 3'b000, "R1 enable alone while reset", {gh, gl}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 R4: first period opens on the all-low zero vector
    check(gl == 3'b111 && gh == 3'b000, "R1 R4 start on all-low zero vector", {gh, gl}, 7);
    track = 1'b1;
    cycles(361 * P + 20);
    track = 1'b0;
    cnt_seen = 0;
    foreach (seen[k]) if (seen[k] && k != 0 && k != 7) cnt_seen++;
    // R3: all six active patterns appear over one revolution
    check(cnt_seen == 6, "R3 active vectors seen in one turn", cnt_seen, 6);

    // R1: enable low forces gates low
    en = 1'b0;
    cycles(2);
    check(gh == 3'b000 && gl == 3'b000, "R1 enable low gates low", {gh, gl}, 0);
    // R6: index below the floor, zero dead time
    midx = 8'd5; freq = 8'd40; dead = 8'd0;
    en = 1'b1;
    cycles(30 * P);

    // R6 R8: index above the ceiling, long dead time
    en = 1'b0;
    cycles(2);
    check(gh == 3'b000 && gl == 3'b000, "R1 enable low again", {gh, gl}, 0);
    midx = 8'd250; dead = 8'd20; freq = 8'd200;
    en = 1'b1;
    cycles(60 * P);

    // R7: zero command keeps the angle still; pattern repeats every two periods
    rst = 1'b1;
    cycles(2);
    check(gh == 3'b000 && gl == 3'b000, "R1 reset mid-run", {gh, gl}, 0);
    freq = 8'd0; midx = 8'd100; dead = 8'd5;
    rst = 1'b0;
    cycles(2 * P + 7);
    for (int i = 0; i < 2 * P; i++) begin
      snap[i] = {gh, gl};
      @(negedge clk);
    end
    diffs = 0;
    for (int i = 0; i < 2 * P; i++) begin
      if ({gh, gl} != snap[i]) diffs++;
      @(negedge clk);
    end
    check(diffs == 0, "R7 still angle repeats", diffs, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule